// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. Each cycle it can take two signed 16-bit operands and an operation code. The first stage multiplies them into a 32-bit product register. On the following cycle, the second stage uses that product to load, add into, subtract from or zero a 40-bit accumulator. The accumulator carries 8 guard bits above the product width. A fresh operation may be issued every cycle without stalls, so a run of multiply-accumulate steps proceeds at one product per cycle.

The product register is visible as a full 32-bit word and through a 16-bit half selector. Either half can also be loaded directly. Its upper half can stand in for the second operand, so a held product feeds a further multiplication. The accumulator is visible as a raw 40-bit value and as a 32-bit value that is clamped whenever the guard bits hold significant data. An immediate overflow flag and a sticky overflow flag report range loss. A synchronous clear input empties the accumulator and drops the sticky flag.

Top module: `mac_unit`

## Requirements
- R1: After reset the accumulator, product register, clamped output, half output and both flags are zero.
- R2: An issue (`in_valid` high) with op code 0, 1 or 2 loads the product register at the next clock edge with the signed product of the two operands. A new issue is accepted every cycle.
- R3: Op code 0 (load) sets the accumulator to the sign-extended product one clock edge after that product enters the product register.
- R4: Op code 1 adds the sign-extended product to the accumulator and op code 2 subtracts it, with the same one-edge lag. Back-to-back issues each take effect on consecutive edges with no stall.
- R5: Op code 3 zeroes the accumulator with the same lag and leaves the product register unchanged.
- R6: `clear` high at an edge sets the accumulator and the sticky flag to zero at that edge. The accumulate step due at that edge is discarded.
- R7: With `reuse_prod` high, the second multiplier operand is bits [31:16] of the current product register instead of `opb`.
- R8: `prod_half` shows product bits [31:16] when `prod_half_sel` is 1 and bits [15:0] when it is 0. `prod_wr[1]` loads `prod_wdata` into bits [31:16] and `prod_wr[0]` loads it into bits [15:0]. A multiplying issue in the same cycle takes precedence over the write.
- R9: `ovf` is high exactly when accumulator bits [39:31] are not all equal. While it is high, `acc_sat` is 0x7FFFFFFF for a positive accumulator and 0x80000000 for a negative one. Otherwise `acc_sat` equals accumulator bits [31:0].
- R10: `ovf_sticky` goes high with any accumulator update whose result is out of 32-bit range. It stays high, even after the accumulator returns to range, until `clear`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe for an operation |
| op | input | 2 | Operation: 0 load, 1 add, 2 subtract, 3 zero |
| opa | input | 16 | First signed operand |
| opb | input | 16 | Second signed operand |
| reuse_prod | input | 1 | Use product bits [31:16] as the second operand |
| clear | input | 1 | Synchronous accumulator and sticky flag clear |
| prod_wr | input | 2 | Half write enables, bit 1 upper, bit 0 lower |
| prod_wdata | input | 16 | Data for product half writes |
| prod_half_sel | input | 1 | Half select for `prod_half` (1 upper, 0 lower) |
| acc | output | 40 | Raw accumulator |
| acc_sat | output | 32 | Clamped 32-bit accumulator view |
| ovf | output | 1 | Accumulator out of 32-bit range |
| ovf_sticky | output | 1 | Held overflow indication |
| prod | output | 32 | Product register |
| prod_half | output | 16 | Selected product half |

## Verification
A corrupted product register shows on `prod` at the first negative clock edge after the issue. It also spreads into `acc` one edge later, because every accumulate step reads that register. A wrong operation code or a lost pipeline valid in the second stage shows as an accumulator value that drifts from the running sum. That difference appears on the edge after the affected issue and persists from then on. Errors in the guard bits are visible only through `ovf`, `ovf_sticky` and `acc_sat`, so the bench drives the accumulator past both 32-bit limits and back again.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MPY = 2'd0,
    OP_MAC = 2'd1,
    OP_MSU = 2'd2,
    OP_CLR = 2'd3
  } mac_op_e;

endpackage

// File: rtl/mac_mult_stage.sv
// First pipeline stage: operand select, signed multiply, product register
// with per-half write access, and the issue tag for the accumulate stage.
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  input  logic [1:0]            issue_op,
  input  logic [OP_W-1:0]       opa,
  input  logic [OP_W-1:0]       opb,
  input  logic                  reuse,
  input  logic [1:0]            wr_en,
  input  logic [OP_W-1:0]       wr_data,
  output logic [2*OP_W-1:0]     prod_q,
  output logic                  stage_valid_q,
  output logic [1:0]            stage_op_q
);

  localparam int PROD_W = 2 * OP_W;
  localparam int HALVES = PROD_W / OP_W;

  logic [OP_W-1:0]          mult_b;
  logic signed [PROD_W-1:0] product;
  logic                     do_mul;
  logic                     prod_en;
  logic [PROD_W-1:0]        prod_d;

  // The held upper half may replace the second operand.
  assign mult_b  = reuse ? prod_q[PROD_W-1 -: OP_W] : opb;
  assign product = PROD_W'($signed(opa)) * PROD_W'($signed(mult_b));
  assign do_mul  = issue_valid && (mac_op_e'(issue_op) != OP_CLR);

  always_comb begin
    prod_d  = prod_q;
    prod_en = do_mul || (|wr_en);
    if (do_mul) begin
      prod_d = product;
    end else begin
      for (int h = 0; h < HALVES; h++) begin
        if (wr_en[h]) prod_d[h*OP_W +: OP_W] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q        <= '0;
      stage_valid_q <= 1'b0;
      stage_op_q    <= '0;
    end else begin
      if (prod_en) prod_q <= prod_d;
      stage_valid_q <= issue_valid;
      stage_op_q    <= issue_op;
    end
  end

endmodule

// File: rtl/mac_acc_stage.sv
// Second pipeline stage: guarded accumulator and sticky overflow.
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int PROD_W = 32,
  parameter int GUARD  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      step_valid,
  input  logic [1:0]                step_op,
  input  logic [PROD_W-1:0]         prod,
  output logic [PROD_W+GUARD-1:0]   acc_q,
  output logic                      sticky_q
);

  localparam int ACC_W = PROD_W + GUARD;

  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] sum;
  logic [GUARD:0]   top_bits;
  logic             sum_fits;
  logic [ACC_W-1:0] acc_d;
  logic             sticky_d;
  logic             acc_en;

  always_comb begin
    prod_ext = {{GUARD{prod[PROD_W-1]}}, prod};
    unique case (mac_op_e'(step_op))
      OP_MPY:  sum = prod_ext;
      OP_MAC:  sum = acc_q + prod_ext;
      OP_MSU:  sum = acc_q - prod_ext;
      default: sum = '0;
    endcase
    top_bits = sum[ACC_W-1:PROD_W-1];
    sum_fits = (&top_bits) || !(|top_bits);
  end

  always_comb begin
    acc_d    = acc_q;
    sticky_d = sticky_q;
    acc_en   = 1'b0;
    if (clear) begin
      acc_d    = '0;
      sticky_d = 1'b0;
      acc_en   = 1'b1;
    end else if (step_valid) begin
      acc_d    = sum;
      sticky_d = sticky_q || !sum_fits;
      acc_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sticky_q <= 1'b0;
    end else if (acc_en) begin
      acc_q    <= acc_d;
      sticky_q <= sticky_d;
    end
  end

endmodule

// File: rtl/mac_sat.sv
// Range check and clamp of the guarded accumulator to the product width.
module mac_sat #(
  parameter int PROD_W = 32,
  parameter int GUARD  = 8
) (
  input  logic [PROD_W+GUARD-1:0] acc,
  output logic [PROD_W-1:0]       acc_sat,
  output logic                    ovf
);

  localparam int ACC_W = PROD_W + GUARD;
  localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

  logic [GUARD:0] upper;

  always_comb begin
    upper = acc[ACC_W-1:PROD_W-1];
    ovf   = !((&upper) || !(|upper));
    if (!ovf)                acc_sat = acc[PROD_W-1:0];
    else if (acc[ACC_W-1])   acc_sat = NEG_LIM;
    else                     acc_sat = POS_LIM;
  end

endmodule

// File: rtl/mac_unit.sv
// Top: reset synchronizer, multiply stage, accumulate stage, clamp view.
module mac_unit #(
  parameter int OP_W        = 16,
  parameter int GUARD       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [1:0]                   op,
  input  logic [OP_W-1:0]              opa,
  input  logic [OP_W-1:0]              opb,
  input  logic                         reuse_prod,
  input  logic                         clear,
  input  logic [1:0]                   prod_wr,
  input  logic [OP_W-1:0]              prod_wdata,
  input  logic                         prod_half_sel,
  output logic [2*OP_W+GUARD-1:0]      acc,
  output logic [2*OP_W-1:0]            acc_sat,
  output logic                         ovf,
  output logic                         ovf_sticky,
  output logic [2*OP_W-1:0]            prod,
  output logic [OP_W-1:0]              prod_half
);

  localparam int PROD_W = 2 * OP_W;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic                   stage_valid;
  logic [1:0]             stage_op;

  // Assert asynchronously, release on the clock.
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end
  endgenerate

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  mac_mult_stage #(.OP_W(OP_W)) u_mult (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .issue_valid   (in_valid),
    .issue_op      (op),
    .opa           (opa),
    .opb           (opb),
    .reuse         (reuse_prod),
    .wr_en         (prod_wr),
    .wr_data       (prod_wdata),
    .prod_q        (prod),
    .stage_valid_q (stage_valid),
    .stage_op_q    (stage_op)
  );

  mac_acc_stage #(.PROD_W(PROD_W), .GUARD(GUARD)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear      (clear),
    .step_valid (stage_valid),
    .step_op    (stage_op),
    .prod       (prod),
    .acc_q      (acc),
    .sticky_q   (ovf_sticky)
  );

  mac_sat #(.PROD_W(PROD_W), .GUARD(GUARD)) u_sat (
    .acc     (acc),
    .acc_sat (acc_sat),
    .ovf     (ovf)
  );

  assign prod_half = prod_half_sel ? prod[PROD_W-1 -: OP_W] : prod[OP_W-1:0];

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W  = 16,
  parameter int GUARD = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              op,
  input logic [OP_W-1:0]         opa,
  input logic [OP_W-1:0]         opb,
  input logic                    reuse_prod,
  input logic                    clear,
  input logic [1:0]              prod_wr,
  input logic [OP_W-1:0]         prod_wdata,
  input logic [2*OP_W+GUARD-1:0] acc,
  input logic [2*OP_W-1:0]       acc_sat,
  input logic                    ovf,
  input logic                    ovf_sticky,
  input logic [2*OP_W-1:0]       prod
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD;
  localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

  logic signed [PROD_W-1:0] exp_prod;
  logic [OP_W-1:0]          b_sel;
  logic                     mul_issue;
  logic [ACC_W-1:0]         prod_ext;

  assign b_sel     = reuse_prod ? prod[PROD_W-1 -: OP_W] : opb;
  assign exp_prod  = PROD_W'($signed(opa)) * PROD_W'($signed(b_sel));
  assign mul_issue = in_valid && (op != 2'd3);
  assign prod_ext  = {{GUARD{prod[PROD_W-1]}}, prod};

  // R2, R7: product register follows the issued operands
  a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
    mul_issue |=> prod == $past(exp_prod));

  // R3: load puts the sign-extended product into the accumulator
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0 && !clear) ##1 !clear |=> acc == $past(prod_ext));

  // R4: add step
  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1 && !clear) ##1 !clear |=> acc == $past(acc) + $past(prod_ext));

  // R4: subtract step
  a_r4_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2 && !clear) ##1 !clear |=> acc == $past(acc) - $past(prod_ext));

  // R5: zero op keeps the product
  a_r5_zero_keeps_prod: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3 && prod_wr == 2'b00) |=> $stable(prod));

  // R6: clear empties accumulator and sticky flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0) && !ovf_sticky);

  // R8: upper half write when no multiply competes
  a_r8_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_wr[1] && !mul_issue) |=> prod[PROD_W-1 -: OP_W] == $past(prod_wdata));

  // R9: clamp values
  a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> acc_sat == (acc[ACC_W-1] ? NEG_LIM : POS_LIM));

  // R9: pass-through when in range
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> acc_sat == acc[PROD_W-1:0]);

  // R10: an out-of-range accumulator always has the sticky flag
  a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ovf_sticky);

  // R10: sticky flag holds until clear
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !clear) |=> ovf_sticky);

endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .GUARD(GUARD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .op         (op),
  .opa        (opa),
  .opb        (opb),
  .reuse_prod (reuse_prod),
  .clear      (clear),
  .prod_wr    (prod_wr),
  .prod_wdata (prod_wdata),
  .acc        (acc),
  .acc_sat    (acc_sat),
  .ovf        (ovf),
  .ovf_sticky (ovf_sticky),
  .prod       (prod)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [15:0] opa, opb;
  logic        reuse_prod;
  logic        clear;
  logic [1:0]  prod_wr;
  logic [15:0] prod_wdata;
  logic        prod_half_sel;
  logic [39:0] acc;
  logic [31:0] acc_sat;
  logic        ovf, ovf_sticky;
  logic [31:0] prod;
  logic [15:0] prod_half;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic signed [39:0] model;

  mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .reuse_prod(reuse_prod), .clear(clear), .prod_wr(prod_wr), .prod_wdata(prod_wdata),
    .prod_half_sel(prod_half_sel), .acc(acc), .acc_sat(acc_sat), .ovf(ovf),
    .ovf_sticky(ovf_sticky), .prod(prod), .prod_half(prod_half)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] smul(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] r;
    r = 32'($signed(x)) * 32'($signed(y));
    return r;
  endfunction

  function automatic logic [39:0] sext(input logic [31:0] p);
    return {{8{p[31]}}, p};
  endfunction

  task automatic drive(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic r);
    in_valid = 1'b1; op = o; opa = x; opb = y; reuse_prod = r;
  endtask

  task automatic idle();
    in_valid = 1'b0; op = 2'd0; opa = '0; opb = '0; reuse_prod = 1'b0;
    clear = 1'b0; prod_wr = 2'b00; prod_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; tick(); clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 acc", acc, 40'h0);
    check("R1 prod", {8'h0, prod}, 40'h0);
    check("R1 acc_sat", {8'h0, acc_sat}, 40'h0);
    check("R1 half", {24'h0, prod_half}, 40'h0);
    check("R1 flags", {38'h0, ovf, ovf_sticky}, 40'h0);
  endtask

  task automatic t_load();
    drive(2'd0, 16'd3, -16'sd5, 1'b0); tick(); idle();
    check("R2 prod 3*-5", {8'h0, prod}, {8'h0, smul(16'd3, -16'sd5)});
    tick();
    check("R3 load acc", acc, sext(smul(16'd3, -16'sd5)));
  endtask

  task automatic t_stream();
    logic [15:0] xa [3];
    logic [15:0] xb [3];
    logic [1:0]  xo [3];
    xa = '{16'd100, -16'sd7, 16'd1000};
    xb = '{16'd200, 16'd9, -16'sd3};
    xo = '{2'd0, 2'd1, 2'd2};
    model = 0;
    for (int i = 0; i < 3; i++) begin
      drive(xo[i], xa[i], xb[i], 1'b0);
      tick();
      check("R2 stream product", {8'h0, prod}, {8'h0, smul(xa[i], xb[i])});
      if (i > 0) check("R4 stream partial", acc, model);
      if (xo[i] == 2'd0)      model = $signed(sext(smul(xa[i], xb[i])));
      else if (xo[i] == 2'd1) model = model + $signed(sext(smul(xa[i], xb[i])));
      else                    model = model - $signed(sext(smul(xa[i], xb[i])));
    end
    idle(); tick();
    check("R4 back-to-back mac/msu total", acc, 40'd22937);
  endtask

  task automatic t_zero_op();
    logic [31:0] held;
    held = prod;
    drive(2'd3, 16'h1111, 16'h2222, 1'b0); tick(); idle();
    check("R5 product kept", {8'h0, prod}, {8'h0, held});
    tick();
    check("R5 acc zeroed", acc, 40'h0);
  endtask

  task automatic t_clear();
    drive(2'd0, 16'd50, 16'd60, 1'b0); tick(); idle();
    clear = 1'b1; tick(); clear = 1'b0;
    check("R6 pending load discarded", acc, 40'h0);
    tick();
    check("R6 acc stays zero", acc, 40'h0);
  endtask

  task automatic t_reuse();
    drive(2'd0, 16'h4000, 16'h0100, 1'b0); tick(); idle();
    check("R7 seed product", {8'h0, prod}, 40'h0000400000);
    drive(2'd0, 16'd3, 16'h7FFF, 1'b1); tick(); idle();
    check("R7 reuse upper half as operand", {8'h0, prod}, 40'h00000000C0);
  endtask

  task automatic t_halves();
    prod_wr = 2'b10; prod_wdata = 16'h1234; tick();
    prod_wr = 2'b01; prod_wdata = 16'hABCD; tick(); idle();
    check("R8 half writes", {8'h0, prod}, 40'h001234ABCD);
    prod_half_sel = 1'b1; #1;
    check("R8 upper half read", {24'h0, prod_half}, 40'h1234);
    prod_half_sel = 1'b0; #1;
    check("R8 lower half read", {24'h0, prod_half}, 40'hABCD);
    drive(2'd1, 16'd2, 16'd4, 1'b0); prod_wr = 2'b11; prod_wdata = 16'hFFFF; tick(); idle();
    check("R8 multiply beats write", {8'h0, prod}, 40'h8);
    do_clear();
  endtask

  task automatic t_overflow();
    drive(2'd0, 16'h8000, 16'h8000, 1'b0); tick();
    drive(2'd1, 16'h8000, 16'h8000, 1'b0); tick(); idle();
    check("R9 in range before", {39'h0, ovf}, 40'h0);
    tick();
    check("R9 positive overflow acc", acc, 40'h0080000000);
    check("R9 ovf high", {39'h0, ovf}, 40'h1);
    check("R9 positive clamp", {8'h0, acc_sat}, 40'h007FFFFFFF);
    check("R10 sticky set", {39'h0, ovf_sticky}, 40'h1);
    drive(2'd2, 16'h8000, 16'h8000, 1'b0); tick(); idle(); tick();
    check("R9 back in range", {39'h0, ovf}, 40'h0);
    check("R9 pass-through", {8'h0, acc_sat}, 40'h0040000000);
    check("R10 sticky holds", {39'h0, ovf_sticky}, 40'h1);
    do_clear();
    check("R10 sticky cleared", {39'h0, ovf_sticky}, 40'h0);
    drive(2'd0, 16'h8000, 16'h7FFF, 1'b0); tick();
    drive(2'd1, 16'h8000, 16'h7FFF, 1'b0); tick();
    drive(2'd1, 16'h8000, 16'h7FFF, 1'b0); tick(); idle(); tick();
    model = 3 * $signed(sext(smul(16'h8000, 16'h7FFF)));
    check("R9 negative overflow acc", acc, model);
    check("R9 negative clamp", {8'h0, acc_sat}, 40'h0080000000);
    check("R10 sticky on negative", {39'h0, ovf_sticky}, 40'h1);
  endtask

  initial begin
    rst_n = 1'b0; prod_half_sel = 1'b0; idle();
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_load();
    t_stream();
    t_zero_op();
    t_clear();
    t_reuse();
    t_halves();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule